// File: doc/BRIEF.md
# Programmable Skew Clock Bank Generator

This block is a synchronous digital model of a skewed clock distribution stage. A fast tick clock sets the time grid, and one tick is one skew time unit. A phase counter builds a base clock whose period is 44, 26 or 16 ticks, depending on a three-level range select. The block drives four banks. Each bank has two identical outputs and carries a copy of the base clock. That copy can be delayed or advanced by whole ticks, divided by two or four, or inverted, as set by the bank's two three-level tap selects. The offset table differs between banks 1/2 and banks 3/4.

A polarity select picks the edge that the outputs align to. A reference marker pulses for one tick at that edge of every base period. A hold input stops banks 1, 2 and 4 at a level that depends on the bank mode and the polarity. Bank 3 keeps running so that it can close an external feedback loop. In test mode, the hold input instead stops only the banks whose tap code is LOW-LOW. Starting and stopping a bank only happens at a point where its output already sits at the stop level, so no shortened pulse appears.

Top module: `skew_clk_bank`

## Requirements
- R1: `ref_mark_o` is high for exactly one tick per base period. The period is 44 ticks for `range_sel_i` = 00 (LOW), 26 for 01 (MID) and 16 for 10 (HIGH). The code 11 acts as MID.
- R2: For banks 1 and 2, the tap code is {F1,F0}. Each is a 2-bit level (00 LOW, 01 MID, 10 HIGH, 11 MID) and the index is 3*F1+F0. Index 0..8 selects an offset of -4..+4 ticks. The output is the base clock (high during phases 0..P/2-1) delayed by that offset, modulo P.
- R3: For bank 3, index 0 divides by two, index 8 divides by four, and indices 1..7 select offsets of -6,-4,-2,0,+2,+4,+6 ticks.
- R4: Bank 4 matches bank 3, except that index 8 selects the inverted base clock.
- R5: With every tap select at MID and polarity HIGH, all eight outputs are equal. They rise in the same tick that `ref_mark_o` is high.
- R6: When `out_hold_i` is high and `test_mode_i` is low, banks 1, 2 and 4 (non-inverted) stop LOW and bank 3 keeps toggling.
- R7: Bank 4 in inverted mode, held, stops at the level of `edge_pol_i`.
- R8: When `test_mode_i` and `out_hold_i` are both high, only banks whose tap index is 0 stop LOW. The other banks keep running with their selected skew.
- R9: With `edge_pol_i` high, the divider counts at base phase 0 (rising edge). With it low, the divider counts at phase P/2 (falling edge), and the marker moves to that edge as well. The divided outputs change only in ticks where `ref_mark_o` is high.
- R10: A bank stops or restarts only when its undelayed-by-gating output equals the stop level. Every high pulse of a zero-skew bank lasts exactly P/2 ticks.
- R11: The two outputs of a bank (`bank_clk_o[2b]`, `bank_clk_o[2b+1]`) are always equal.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one skew time unit per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| range_sel_i | input | 2 | Three-level range select (00 LOW, 01 MID, 10 HIGH, 11 MID) |
| tap_sel_i | input | 16 | Per bank b: [4b+3:4b+2] F1 level, [4b+1:4b] F0 level |
| edge_pol_i | input | 1 | 1: align to rising edge, 0: align to falling edge |
| out_hold_i | input | 1 | Synchronous stop request |
| test_mode_i | input | 1 | Restricts stopping to banks with tap index 0 |
| bank_clk_o | output | 8 | Bank clocks, pair b at bits [2b+1:2b] |
| ref_mark_o | output | 1 | One-tick marker at the aligned base edge |

## Verification
The bench uses the default periods of 44, 26 and 16 ticks and switches between all three ranges. This exercises the wrap of the phase counter and the modulo correction for the largest negative offset of -6. With these periods, a divide-by-four output spans up to 176 ticks, so all four divider phases are covered under both polarities. The full nine-entry tap table is swept on every bank. The hold input is toggled at phases that fall inside high pulses, which tests the no-runt rule.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int unsigned NUM_BANKS = 4;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_DIV2  = 2'd1,
    MODE_DIV4  = 2'd2,
    MODE_INV   = 2'd3
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e       mode;
    logic signed [3:0] ofs;
    logic             lo_lo;
  } tap_cfg_t;

  function automatic int unsigned level3(input logic [1:0] code);
    return (code == 2'b00) ? 0 : (code == 2'b10) ? 2 : 1;
  endfunction

  function automatic tap_cfg_t tap_decode(input int unsigned bank, input logic [3:0] code);
    tap_cfg_t    cfg;
    int unsigned idx;
    idx       = 3 * level3(code[3:2]) + level3(code[1:0]);
    cfg.mode  = MODE_SHIFT;
    cfg.ofs   = '0;
    cfg.lo_lo = (idx == 0);
    if (bank < 2) begin
      cfg.ofs = 4'(int'(idx) - 4);
    end else if (idx == 0) begin
      cfg.mode = MODE_DIV2;
    end else if (idx == 8) begin
      cfg.mode = (bank == 2) ? MODE_DIV4 : MODE_INV;
    end else begin
      cfg.ofs = 4'(2 * (int'(idx) - 4));
    end
    return cfg;
  endfunction
endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
  parameter int unsigned PER_LO = 44,
  parameter int unsigned PER_MD = 26,
  parameter int unsigned PER_HI = 16,
  parameter int unsigned PW     = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    range_sel_i,
  input  logic          edge_pol_i,
  output logic [PW-1:0] ph_o,
  output logic [PW-1:0] per_o,
  output logic [1:0]    div_cnt_o,
  output logic          ref_mark_o
);
  logic [PW-1:0] ph_q;
  logic [PW-1:0] anchor;
  logic [1:0]    cnt_q;
  logic          hit;

  always_comb begin
    unique case (range_sel_i)
      2'b00:   per_o = PW'(PER_LO);
      2'b10:   per_o = PW'(PER_HI);
      default: per_o = PW'(PER_MD);
    endcase
  end

  assign anchor    = edge_pol_i ? '0 : (per_o >> 1);
  assign hit       = (ph_q == anchor);
  assign div_cnt_o = cnt_q + {1'b0, hit};
  assign ph_o      = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= '0;
      cnt_q      <= '0;
      ref_mark_o <= 1'b0;
    end else begin
      // range change may leave ph_q beyond the new period: wrap at once
      ph_q       <= (ph_q >= per_o - PW'(1)) ? '0 : ph_q + PW'(1);
      cnt_q      <= div_cnt_o;
      ref_mark_o <= hit;
    end
  end
endmodule

// File: rtl/skew_bank_lane.sv
module skew_bank_lane
  import skew_pkg::*;
#(
  parameter int unsigned BANK = 0,
  parameter int unsigned PW   = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ph_i,
  input  logic [PW-1:0] per_i,
  input  logic [1:0]    div_cnt_i,
  input  logic [3:0]    tap_i,
  input  logic          edge_pol_i,
  input  logic          hold_i,
  input  logic          test_i,
  output logic          clk_o
);
  tap_cfg_t cfg;
  logic     raw, stop_lvl, stop_req, en_q, en_nx;
  int       half, sph;

  assign cfg = tap_decode(BANK, tap_i);

  always_comb begin
    half = int'(per_i) >> 1;
    // negative offsets become positive delays modulo the period
    sph  = int'(ph_i) + int'(per_i) - int'($signed(cfg.ofs));
    if (sph >= 2 * int'(per_i)) sph = sph - 2 * int'(per_i);
    else if (sph >= int'(per_i)) sph = sph - int'(per_i);
    unique case (cfg.mode)
      MODE_DIV2: raw = div_cnt_i[0];
      MODE_DIV4: raw = div_cnt_i[1];
      MODE_INV:  raw = !(int'(ph_i) < half);
      default:   raw = (sph < half);
    endcase
  end

  generate
    if (BANK == 2) begin : g_fb_bank
      assign stop_req = hold_i && test_i && cfg.lo_lo;
    end else begin : g_std_bank
      assign stop_req = hold_i && (test_i ? cfg.lo_lo : 1'b1);
    end
  endgenerate

  assign stop_lvl = (cfg.mode == MODE_INV) ? edge_pol_i : 1'b0;
  // gate state may change only where the lane already sits at the stop level
  assign en_nx    = (raw == stop_lvl) ? !stop_req : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      clk_o <= 1'b0;
    end else begin
      en_q  <= en_nx;
      clk_o <= en_nx ? raw : stop_lvl;
    end
  end
endmodule

// File: rtl/skew_clk_bank.sv
module skew_clk_bank
  import skew_pkg::*;
#(
  parameter int unsigned PER_LO = 44,
  parameter int unsigned PER_MD = 26,
  parameter int unsigned PER_HI = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             range_sel_i,
  input  logic [4*NUM_BANKS-1:0] tap_sel_i,
  input  logic                   edge_pol_i,
  input  logic                   out_hold_i,
  input  logic                   test_mode_i,
  output logic [2*NUM_BANKS-1:0] bank_clk_o,
  output logic                   ref_mark_o
);
  localparam int unsigned PER_MAX = (PER_LO > PER_MD) ? ((PER_LO > PER_HI) ? PER_LO : PER_HI)
                                                      : ((PER_MD > PER_HI) ? PER_MD : PER_HI);
  localparam int unsigned PW      = $clog2(PER_MAX) + 1;

  logic [PW-1:0] ph, per;
  logic [1:0]    div_cnt;

  skew_phase_gen #(
    .PER_LO(PER_LO), .PER_MD(PER_MD), .PER_HI(PER_HI), .PW(PW)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .range_sel_i(range_sel_i),
    .edge_pol_i (edge_pol_i),
    .ph_o       (ph),
    .per_o      (per),
    .div_cnt_o  (div_cnt),
    .ref_mark_o (ref_mark_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic lane_clk;
    skew_bank_lane #(.BANK(b), .PW(PW)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ph_i      (ph),
      .per_i     (per),
      .div_cnt_i (div_cnt),
      .tap_i     (tap_sel_i[4*b +: 4]),
      .edge_pol_i(edge_pol_i),
      .hold_i    (out_hold_i),
      .test_i    (test_mode_i),
      .clk_o     (lane_clk)
    );
    assign bank_clk_o[2*b +: 2] = {2{lane_clk}};
  end
endmodule

// File: rtl/skew_clk_bank_chk.sv
module skew_clk_bank_chk #(
  parameter int unsigned PER_LO = 44,
  parameter int unsigned PER_MD = 26,
  parameter int unsigned PER_HI = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  range_sel_i,
  input logic [15:0] tap_sel_i,
  input logic        edge_pol_i,
  input logic        out_hold_i,
  input logic        test_mode_i,
  input logic [7:0]  bank_clk_o,
  input logic        ref_mark_o
);
  logic [15:0] gap_q;
  logic        seen_q, chg_q, chg_d1;
  logic [1:0]  rng_prev, rng_at;
  logic        pol_prev, mod_now;
  int unsigned exp_per;

  assign mod_now = (range_sel_i != rng_prev) || (edge_pol_i != pol_prev) || chg_d1;
  assign exp_per = (rng_at == 2'b00) ? PER_LO : (rng_at == 2'b10) ? PER_HI : PER_MD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; seen_q <= 1'b0; chg_q <= 1'b0; chg_d1 <= 1'b0;
      rng_prev <= '0; rng_at <= '0; pol_prev <= 1'b0;
    end else begin
      rng_prev <= range_sel_i;
      pol_prev <= edge_pol_i;
      chg_d1   <= (range_sel_i != rng_prev) || (edge_pol_i != pol_prev);
      if (ref_mark_o) begin
        gap_q <= 16'd1; seen_q <= 1'b1; rng_at <= range_sel_i; chg_q <= mod_now;
      end else begin
        gap_q <= gap_q + 16'd1; chg_q <= chg_q | mod_now;
      end
    end
  end

  AST_REF_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_mark_o |=> !ref_mark_o); // R1

  AST_REF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_mark_o && seen_q && !chg_q && !mod_now && rng_at == range_sel_i)
      |-> (32'(gap_q) == exp_per)); // R1

  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && out_hold_i && !test_mode_i && $past(out_hold_i && !test_mode_i)
      && !bank_clk_o[0]) |=> !bank_clk_o[0]); // R6

  AST_INV_STOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && out_hold_i && !test_mode_i && tap_sel_i[15:12] == 4'b1010
      && $past(out_hold_i && !test_mode_i && tap_sel_i[15:12] == 4'b1010)
      && $stable(edge_pol_i) && bank_clk_o[6] == edge_pol_i)
      |=> (bank_clk_o[6] == $past(edge_pol_i))); // R7

  AST_TEST_LL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && out_hold_i && test_mode_i && tap_sel_i[3:0] == 4'b0000
      && $past(out_hold_i && test_mode_i && tap_sel_i[3:0] == 4'b0000)
      && !bank_clk_o[0]) |=> !bank_clk_o[0]); // R8
endmodule

bind skew_clk_bank skew_clk_bank_chk #(
  .PER_LO(PER_LO), .PER_MD(PER_MD), .PER_HI(PER_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .range_sel_i(range_sel_i),
  .tap_sel_i  (tap_sel_i),
  .edge_pol_i (edge_pol_i),
  .out_hold_i (out_hold_i),
  .test_mode_i(test_mode_i),
  .bank_clk_o (bank_clk_o),
  .ref_mark_o (ref_mark_o)
);

// File: tb/skew_clk_bank_tb.sv
module skew_clk_bank_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  rng = 2'b01;
  logic [15:0] tap = 16'h5555;
  logic        pol = 1'b1, hold = 1'b0, test = 1'b0;
  logic [7:0]  bclk;
  logic        refm;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  string tag = "R2";

  skew_clk_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .range_sel_i(rng), .tap_sel_i(tap),
    .edge_pol_i(pol), .out_hold_i(hold), .test_mode_i(test),
    .bank_clk_o(bclk), .ref_mark_o(refm)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic int period_of(input logic [1:0] r);
    return (r == 2'b00) ? 44 : (r == 2'b10) ? 16 : 26;
  endfunction

  // behavioural reference
  int m_ph = 0, m_cnt = 0;
  bit m_en[4], m_out[4], m_ref;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ref = 0;
      foreach (m_en[b]) begin m_en[b] = 1; m_out[b] = 0; end
    end else begin
      int per, half, anc, cn, idx, k, s;
      bit hit, raw, sl, req;
      per = period_of(rng); half = per / 2; anc = pol ? 0 : half;
      hit = (m_ph == anc);
      cn  = (m_cnt + (hit ? 1 : 0)) % 4;
      for (int b = 0; b < 4; b++) begin
        idx = 3 * lvl(tap[4*b+2 +: 2]) + lvl(tap[4*b +: 2]);
        k = 0; raw = 0;
        if (b < 2) k = idx - 4;
        else if (idx != 0 && idx != 8) k = 2 * (idx - 4);
        s = ((m_ph - k) % per + per) % per;
        if (b >= 2 && idx == 0) raw = cn[0];
        else if (b == 2 && idx == 8) raw = cn[1];
        else if (b == 3 && idx == 8) raw = !(m_ph < half);
        else raw = (s < half);
        sl  = (b == 3 && idx == 8) ? pol : 1'b0;
        req = hold && (test ? (idx == 0) : (b != 2));
        if (raw == sl) m_en[b] = !req;
        m_out[b] = m_en[b] ? raw : sl;
      end
      m_ref = hit; m_cnt = cn;
      m_ph = (m_ph >= per - 1) ? 0 : m_ph + 1;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    for (int b = 0; b < 4; b++) begin
      check(bclk[2*b] == m_out[b], tag, bclk[2*b], m_out[b]);
      check(bclk[2*b] == bclk[2*b+1], "R11", bclk[2*b+1], bclk[2*b]);
    end
    check(refm == m_ref, tag, refm, m_ref);
  end

  // R10: full-length high pulses on zero-skew bank 1
  bit mon_on = 0, armed = 0;
  int run = 0;
  always @(negedge clk) begin
    if (!mon_on) begin armed = 0; run = 0; end
    else if (bclk[0]) run++;
    else begin
      if (armed && run != 0) check(run == 13, "R10", run, 13);
      armed = 1; run = 0;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_period(input logic [1:0] r);
    int cnt;
    rng = r; ticks(120);
    while (!refm) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!refm);
    check(cnt == period_of(r), "R1", cnt, period_of(r));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int tog, chg, bad;
    bit prev;
    ticks(3);
    check(bclk == 8'h00 && refm == 1'b0, "R12", {refm, bclk}, 0);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1;

    // R5: all MID
    tag = "R5"; ticks(30);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk != 8'h00 && bclk != 8'hFF) bad++;
      if (refm && bclk != 8'hFF) bad++;
    end
    check(bad == 0, "R5", bad, 0);

    tag = "R1";
    measure_period(2'b00); measure_period(2'b01);
    measure_period(2'b10); measure_period(2'b11);

    tag = "R2"; rng = 2'b10;
    for (int i = 0; i < 9; i++) begin
      tap[3:0]  = 4'((i / 3) << 2 | (i % 3));
      tap[7:4]  = 4'(((8 - i) / 3) << 2 | ((8 - i) % 3));
      ticks(60);
    end
    tap = 16'h5555;

    tag = "R3 R4"; rng = 2'b00;
    for (int i = 0; i < 9; i++) begin
      tap[11:8]  = 4'((i / 3) << 2 | (i % 3));
      tap[15:12] = 4'(((8 - i) / 3) << 2 | ((8 - i) % 3));
      ticks(200);
      pol = ~pol; ticks(200); pol = 1'b1;
    end
    tap = 16'h5555; rng = 2'b01;

    // R6
    tag = "R6"; hold = 1'b1; ticks(60);
    tog = 0; bad = 0; prev = bclk[4];
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk[4] != prev) tog++;
      prev = bclk[4];
      if (bclk[1:0] != 0 || bclk[3:2] != 0 || bclk[7:6] != 0) bad++;
    end
    check(bad == 0, "R6", bad, 0);
    check(tog > 0, "R6", tog, 1);
    hold = 1'b0; ticks(40);

    // R7
    tag = "R7"; tap[15:12] = 4'b1010; hold = 1'b1; ticks(40);
    check(bclk[7:6] == 2'b11, "R7", bclk[7:6], 3);
    pol = 1'b0; ticks(40);
    check(bclk[7:6] == 2'b00, "R7", bclk[7:6], 0);
    pol = 1'b1; hold = 1'b0; tap = 16'h5555; ticks(40);

    // R8
    tag = "R8"; test = 1'b1; tap[3:0] = 4'b0000; hold = 1'b1; ticks(60);
    tog = 0; bad = 0; prev = bclk[2];
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk[2] != prev) tog++;
      prev = bclk[2];
      if (bclk[1:0] != 0) bad++;
    end
    check(bad == 0, "R8", bad, 0);
    check(tog > 0, "R8", tog, 1);
    hold = 1'b0; test = 1'b0; tap = 16'h5555; ticks(40);

    // R9: falling-edge alignment of divided bank 3
    tag = "R9"; pol = 1'b0; tap[11:8] = 4'b0000; ticks(80);
    chg = 0; bad = 0; prev = bclk[4];
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (bclk[4] != prev) begin chg++; if (!refm) bad++; end
      prev = bclk[4];
    end
    check(bad == 0 && chg > 0, "R9", bad, 0);
    pol = 1'b1; tap = 16'h5555; ticks(60);

    // R10: hold toggled at awkward phases
    tag = "R10"; mon_on = 1;
    for (int i = 0; i < 12; i++) begin
      hold = 1'b1; ticks(7 + 3 * i);
      hold = 1'b0; ticks(11 + 5 * i);
    end
    mon_on = 0; ticks(40);

    cmp_on = 0; done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule